// File: doc/BRIEF.md
# Shared Pin-Transition Interrupt Detector

This block watches eight general-purpose pins, arranged as two 4-bit ports, and raises a single interrupt request when any pin that is configured as an input makes a transition to the active level. A polarity input chooses the active level: falling transitions (high to low) or rising transitions (low to high). Pins whose direction bit marks them as outputs are excluded.

The detector has a lockout. Once a request has fired, it ignores every further transition until all participating pins have returned to the idle level together. Idle is high in falling mode and low in rising mode. The request is held in a flag until software clears it. Clearing the flag does not re-arm the detector. The request output is the flag gated by an enable input.

Changing the polarity or any direction bit disarms the detector. This prevents the new configuration from producing a false request. Each pin passes through a two-stage synchronizer before it is examined.

Top module: `pcid_top`

## Requirements
- R1: While reset is asserted and after its release, `irq_o` is 0. After reset the detector starts disarmed. A pin that is already at the active level does not raise a request until all participating pins have been idle.
- R2: With `rise_sel_i` = 0 (falling mode), suppose the detector is armed and a participating pin changes from 1 to 0 before rising clock edge k. The request flag is then set at edge k+2. With `irq_en_i` = 1, `irq_o` is 1 after edge k+2 and still 0 after edge k+1.
- R3: With `rise_sel_i` = 1 (rising mode), a 0 to 1 change on a participating pin raises the request with the same timing as R2. Re-arming then needs all participating pins to be low.
- R4: A pin whose `dir_i` bit is 1 (output) never raises a request and never blocks re-arming. A pin whose `dir_i` bit is 0 (input) takes part in detection.
- R5: After a request fires, transitions on any pin are ignored until every participating pin has been seen at the idle level. After that, the next active transition raises a new request.
- R6: Active transitions on several pins in the same cycle produce exactly one request.
- R7: The flag stays set until `irq_clr_i` is 1 at a rising edge, which clears it. Clearing does not re-arm the detector.
- R8: `irq_o` is the flag ANDed with `irq_en_i`, combinationally. A flag set while `irq_en_i` = 0 appears at `irq_o` as soon as the enable is raised.
- R9: In any cycle where `rise_sel_i` or `dir_i` differs from its value at the previous rising edge, no request fires and the detector becomes disarmed. The detector re-arms only through the all-idle condition. After reset, the previous values are taken as `dir_i` all 0 and `rise_sel_i` = 1.
- R10: If a request fires in the same cycle as `irq_clr_i` = 1, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Pin levels; bits 3:0 first port, bits 7:4 second port |
| dir_i | input | 8 | Direction per pin; 1 = output (masked), 0 = input |
| rise_sel_i | input | 1 | Polarity; 0 = falling, 1 = rising |
| irq_en_i | input | 1 | Request output enable |
| irq_clr_i | input | 1 | Clears the request flag at a clock edge |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences separate a first edge from later edges on other pins while one is still held active. This shows that the lockout works and that the clear does not re-arm. They also compare simultaneous edges with single ones, and masked pins with unmasked ones. Polarity and direction changes are applied while the pins are held at the newly active level, which would expose a false trigger. A fired request coinciding with a clear tests the priority. Random pin, direction, polarity, clear and enable traffic is then compared every cycle against a cycle-level reference model. That traffic exercises interleavings the directed cases do not reach, in both polarities.

// File: rtl/pcid_pkg.sv
package pcid_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;

   typedef struct packed {
      logic armed;
      logic flag;
   } det_state_t;
endpackage

// File: rtl/pcid_sync.sv
module pcid_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [STAGES];

   initial begin : chk_params
      assert (STAGES >= 2) else $fatal(1, "pcid_sync: STAGES must be at least 2");
      assert (W >= 1) else $fatal(1, "pcid_sync: W must be positive");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcid_level.sv
module pcid_level #(
   parameter int PORT_W    = 4,
   parameter int NUM_PORTS = 2,
   localparam int W        = PORT_W * NUM_PORTS
) (
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] dir,
   input  logic         rise_sel,
   output logic         any_act
);
   logic [W-1:0]         act_lvl;
   logic [NUM_PORTS-1:0] port_hit;

   initial begin : chk_params
      assert (PORT_W >= 1 && NUM_PORTS >= 1)
         else $fatal(1, "pcid_level: port geometry must be positive");
   end

   assign act_lvl = (rise_sel == pcid_pkg::EDGE_RISE) ? pin_s : ~pin_s;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_hit[p] = |(act_lvl[p*PORT_W +: PORT_W] & ~dir[p*PORT_W +: PORT_W]);
   end

   assign any_act = |port_hit;
endmodule

// File: rtl/pcid_arm.sv
module pcid_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic any_act,
   input  logic cfg_chg,
   input  logic clr,
   output logic armed,
   output logic flag,
   output logic fire
);
   pcid_pkg::det_state_t st_q, st_d;

   assign fire = st_q.armed & any_act & ~cfg_chg;

   always_comb begin
      st_d = st_q;
      if (cfg_chg || fire)               st_d.armed = 1'b0;
      else if (!st_q.armed && !any_act)  st_d.armed = 1'b1;
      if (fire)      st_d.flag = 1'b1;
      else if (clr)  st_d.flag = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign armed = st_q.armed;
   assign flag  = st_q.flag;

   // R5: a fired request leaves the detector disarmed
   p_disarm_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed);

   // R7: the flag only falls when a clear was presented
   p_clear_only_by_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr));
endmodule

// File: rtl/pcid_top.sv
module pcid_top #(
   parameter int PORT_W      = 4,
   parameter int NUM_PORTS   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int PINS       = PORT_W * NUM_PORTS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin_i,
   input  logic [PINS-1:0] dir_i,
   input  logic            rise_sel_i,
   input  logic            irq_en_i,
   input  logic            irq_clr_i,
   output logic            irq_o
);
   logic [PINS-1:0] pin_s;
   logic [PINS-1:0] dir_q;
   logic            rise_q;
   logic            any_act;
   logic            cfg_chg;
   logic            armed;
   logic            flag;
   logic            fire;

   pcid_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_i),
      .dout (pin_s)
   );

   pcid_level #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_level (
      .pin_s   (pin_s),
      .dir     (dir_i),
      .rise_sel(rise_sel_i),
      .any_act (any_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         rise_q <= pcid_pkg::EDGE_RISE;
      end else begin
         dir_q  <= dir_i;
         rise_q <= rise_sel_i;
      end
   end

   assign cfg_chg = (dir_i != dir_q) || (rise_sel_i != rise_q);

   pcid_arm u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .any_act(any_act),
      .cfg_chg(cfg_chg),
      .clr    (irq_clr_i),
      .armed  (armed),
      .flag   (flag),
      .fire   (fire)
   );

   assign irq_o = flag & irq_en_i;

   // R9: a configuration change always leaves the detector disarmed
   p_cfg_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !armed);

   // R5: re-arming only happens after an all-idle cycle
   p_rearm_on_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(!any_act));

   // R2: a new request needs the detector armed in the cycle before
   p_set_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(armed));

   // R1: no request output while reset is held
   always_comb begin
      if (!rst_n) p_quiet_in_reset_r1: assert (irq_o == 1'b0);
   end
endmodule

// File: tb/tb_pcid_top.sv
module tb_pcid_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins = 8'hFF;
   logic [7:0] dir = 8'h00;
   logic       rise = 1'b1;
   logic       en = 1'b0;
   logic       clr = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] m_s1, m_s2, m_dq;
   logic       m_rq, m_armed, m_flag;

   pcid_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pins),
      .dir_i     (dir),
      .rise_sel_i(rise),
      .irq_en_i  (en),
      .irq_clr_i (clr),
      .irq_o     (irq)
   );

   always #5 clk = ~clk;

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_dq = '0; m_rq = 1'b1; m_armed = 1'b0; m_flag = 1'b0;
   endtask

   function automatic logic model_any(input logic [7:0] s, input logic [7:0] d, input logic r);
      return |((r ? s : ~s) & ~d);
   endfunction

   task automatic model_edge();
      logic any, chg, f;
      any = model_any(m_s2, dir, rise);
      chg = (dir != m_dq) || (rise != m_rq);
      f   = m_armed & any & ~chg;
      if (chg || f)               m_armed = 1'b0;
      else if (!m_armed && !any)  m_armed = 1'b1;
      if (f)        m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      m_s2 = m_s1; m_s1 = pins; m_dq = dir; m_rq = rise;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         if (rst_n) model_edge();
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s irq_o actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned r;
      model_reset();
      r = $urandom(32'h5EED_0101);
      #1;
      check("R1", irq, 1'b0);
      step(3);
      check("R1", irq, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // falling mode, all pins high and idle
      rise = 1'b0; en = 1'b1;
      step(6);
      check("R1", irq, 1'b0);

      // R2: single falling edge, request after third edge
      pins[0] = 1'b0;
      step(2); check("R2", irq, 1'b0);
      step(1); check("R2", irq, 1'b1);

      // R7: clear drops the flag; R5: other pins locked out
      clr = 1'b1; step(1); clr = 1'b0;
      check("R7", irq, 1'b0);
      pins[5] = 1'b0; step(6);
      check("R5", irq, 1'b0);
      pins[6] = 1'b0; step(6);
      check("R7", irq, 1'b0);

      // R5: return all idle, then re-arm and fire again
      pins = 8'hFF; step(6);
      check("R5", irq, 1'b0);
      pins[3] = 1'b0; step(3);
      check("R5", irq, 1'b1);
      clr = 1'b1; step(1); clr = 1'b0;
      pins = 8'hFF; step(6);

      // R6: simultaneous edges give one request
      pins[1] = 1'b0; pins[2] = 1'b0; step(3);
      check("R6", irq, 1'b1);
      clr = 1'b1; step(1); clr = 1'b0;
      step(6);
      check("R6", irq, 1'b0);
      pins = 8'hFF; step(6);

      // R4: masked output pin does not trigger or block re-arm
      dir[7] = 1'b1; step(6);
      pins[7] = 1'b0; step(6);
      check("R4", irq, 1'b0);
      pins[4] = 1'b0; step(3);
      check("R4", irq, 1'b1);
      clr = 1'b1; step(1); clr = 1'b0;
      pins[6:0] = 7'h7F; step(6);
      pins[0] = 1'b0; step(3);
      check("R4", irq, 1'b1);
      clr = 1'b1; step(1); clr = 1'b0;
      pins = 8'hFF; dir = 8'h00; step(6);

      // R8: flag set while disabled appears once enabled
      en = 1'b0;
      pins[4] = 1'b0; step(6);
      check("R8", irq, 1'b0);
      en = 1'b1; #1;
      check("R8", irq, 1'b1);
      @(negedge clk);
      clr = 1'b1; step(1); clr = 1'b0;

      // R9: polarity change with pins at new active level
      pins = 8'hFF; step(6);
      rise = 1'b1; step(8);
      check("R9", irq, 1'b0);

      // R3: rising mode
      pins = 8'h00; step(6);
      pins[2] = 1'b1;
      step(2); check("R3", irq, 1'b0);
      step(1); check("R3", irq, 1'b1);
      clr = 1'b1; step(1); clr = 1'b0;
      pins = 8'h00; step(6);

      // R9: unmasking a pin already active does not fire
      dir[6] = 1'b1; step(4);
      pins[6] = 1'b1; step(6);
      check("R9", irq, 1'b0);
      dir[6] = 1'b0; step(8);
      check("R9", irq, 1'b0);
      pins = 8'h00; step(6);

      // R10: fire coinciding with clear leaves the flag set
      clr = 1'b1; pins[1] = 1'b1;
      step(3);
      check("R10", irq, 1'b1);
      step(1);
      check("R7", irq, 1'b0);
      clr = 1'b0; pins = 8'h00; step(6);

      // random traffic against the reference model
      for (int c = 0; c < 6000; c++) begin
         r = $urandom;
         if (r[2:0] == 3'd0) pins[r[10:8]] = ~pins[r[10:8]];
         if (r[16:11] == 6'd0) rise = ~rise;
         if (r[22:17] == 6'd1) dir[r[25:23]] = ~dir[r[25:23]];
         clr = (r[29:26] == 4'd0);
         if (r[31:27] == 5'd3) en = ~en;
         step(1);
         check(rise ? "R3" : "R2", irq, m_flag & en);
      end

      finish_run();
   end
endmodule